// File: doc/BRIEF.md
# Wake Frame Detector and Suspend Controller

This block sits beside a receive MAC and watches the byte stream of each incoming frame while a wake mode is armed. It looks for a run of 0xFF synchronisation bytes followed by repeated copies of the station address. When it finds one in a frame that then ends without error, three sticky status flags are set. The frame is marked for internal discard, and the descriptor engine is told to hold normal traffic.

Three outputs are gated separately from the status flags. A power-management event is gated by an enable bit or its override. An interrupt needs both a global enable and a wake enable. An indicator pin has a select bit and programmable polarity.

The wake mode is armed only while the mode bit is set and power-good has been low for a minimum time. Suspension lasts until power-good rises or the mode bit is cleared. Traffic then resumes from where it stopped.

Top module: `wake_frame_ctrl`

## Requirements
- R1: A wake frame has `SYNC_LEN` (6) consecutive 0xFF bytes, then `ADDR_COPIES` (16) back-to-back copies of `station_addr`, with each copy sent most significant byte first (bits 47:40 first). It may start at any byte of the frame. If a frame containing one ends with `rx_eof` high and `rx_err` low while the mode is armed, then `match_flag`, `wake_irq_flag` and `pm_status_flag` are all 1 from the clock edge that samples that `rx_eof`.
- R2: A frame that ends with `rx_err` high sets no flag and gives no `frame_drop`. An `rx_sof`, an `rx_eof`, or any cycle in which the mode is not armed discards a partial match.
- R3: `pm_event` is 1 exactly when `pm_status_flag` is 1 and at least one of `pm_evt_en` or `pm_evt_ovr` is 1.
- R4: `irq` is 1 exactly when `wake_irq_flag`, `irq_global_en` and `irq_wake_en` are all 1.
- R5: Let the active state be `ind_sel` AND `match_flag`. `indicator` equals the active state when `ind_pol` is 1, and its inverse when `ind_pol` is 0.
- R6: `frame_drop` is a one-cycle pulse in the same cycle as the flags are first set by a detection.
- R7: `rx_suspend` goes to 1 at detection. It returns to 0 after the first edge at which `pwr_good` is 1 or `mode_en` is 0. Nothing else clears it.
- R8: The mode is armed only when all of these hold: `mode_en` is 1, `pwr_good` is 0, and `pwr_good` was 0 at the last `LOW_CYC` consecutive clock edges. `LOW_CYC` is ceil(`MIN_LOW_PS` / `CLK_PERIOD_PS`). Any edge with `pwr_good` high, and reset, restarts that count.
- R9: Clearing `mode_en` and setting it again re-arms at once, with no wait, as long as `pwr_good` stayed low.
- R10: Each flag clears on the edge after its write-one-to-clear strobe (`clr_match`, `clr_wake_irq`, `clr_pm_status`). A detection in the same cycle wins over the clear.
- R11: A byte that breaks the sequence restarts the search. If that byte is 0xFF, it counts as the first byte of a new sync run. 0xFF bytes beyond the sixth, before the first address byte, keep the sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Frame start strobe, no data |
| rx_valid | input | 1 | Byte valid on rx_data |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Frame end strobe, no data |
| rx_err | input | 1 | Frame ended with error, qualifies rx_eof |
| station_addr | input | 48 | Station address, bits 47:40 received first |
| mode_en | input | 1 | Wake mode enable |
| pm_evt_en | input | 1 | Power-management event enable |
| pm_evt_ovr | input | 1 | Override event enable |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_wake_en | input | 1 | Wake interrupt enable |
| ind_sel | input | 1 | Indicator shows wake reception |
| ind_pol | input | 1 | Indicator active high when 1 |
| pwr_good | input | 1 | Power-good pin |
| clr_match | input | 1 | Write-one-to-clear for match_flag |
| clr_wake_irq | input | 1 | Write-one-to-clear for wake_irq_flag |
| clr_pm_status | input | 1 | Write-one-to-clear for pm_status_flag |
| match_flag | output | 1 | Sticky wake-frame match |
| wake_irq_flag | output | 1 | Sticky wake interrupt status |
| pm_status_flag | output | 1 | Sticky power-management status |
| pm_event | output | 1 | Power-management event |
| irq | output | 1 | Interrupt |
| indicator | output | 1 | Polarity-programmable indicator |
| frame_drop | output | 1 | Discard pulse for the detected frame |
| rx_suspend | output | 1 | Hold normal receive/transmit |

## Verification
The bench uses the default parameters: a 20 ns clock period and a 200 ns minimum low time, which gives a 10-cycle qualification window. Frames that start right after power-good falls therefore straddle the arming point, and a 16-copy pattern (102 bytes) fits many times into the run. The station addresses used contain no 0xFF byte. That makes greedy restart matching equal to a sliding-window search, so the bench's queue-based window model can judge every frame, including broken and overlapping patterns.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam logic [7:0] SYNC_BYTE  = 8'hFF;
    localparam int         ADDR_BYTES = 6;

    typedef struct packed {
        logic match;
        logic wake_irq;
        logic pm_status;
    } wake_flags_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Byte i of the address in reception order (i = 0 is bits 47:40).
    function automatic logic [7:0] addr_byte(input logic [47:0] addr, input logic [2:0] idx);
        logic [47:0] shifted;
        shifted = addr << (8 * idx);
        return shifted[47:40];
    endfunction

endpackage

// File: rtl/wake_seq_matcher.sv
module wake_seq_matcher
    import wake_pkg::*;
#(
    parameter int SYNC_LEN    = 6,
    parameter int ADDR_COPIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        byte_vld,
    input  logic [7:0]  byte_d,
    input  logic [47:0] addr,
    output logic        found
);
    localparam int SW = $clog2(SYNC_LEN + 1);
    localparam int CW = $clog2(ADDR_COPIES + 1);
    localparam int IW = $clog2(ADDR_BYTES);

    logic [SW-1:0] sync_cnt;
    logic [CW-1:0] copy_cnt;
    logic [IW-1:0] idx;
    logic [7:0]    exp_byte;
    logic          at_first;

    assign exp_byte = addr_byte(addr, 3'(idx));
    assign at_first = (copy_cnt == '0) && (idx == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sync_cnt <= '0;
            copy_cnt <= '0;
            idx      <= '0;
            found    <= 1'b0;
        end else if (byte_vld && !found) begin
            if (sync_cnt < SW'(SYNC_LEN)) begin
                sync_cnt <= (byte_d == SYNC_BYTE) ? sync_cnt + 1'b1 : '0;
            end else if (byte_d == exp_byte) begin
                if (idx == IW'(ADDR_BYTES - 1)) begin
                    idx <= '0;
                    copy_cnt <= copy_cnt + 1'b1;
                    if (copy_cnt == CW'(ADDR_COPIES - 1)) found <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else begin
                idx      <= '0;
                copy_cnt <= '0;
                if (byte_d == SYNC_BYTE)
                    sync_cnt <= at_first ? SW'(SYNC_LEN) : SW'(1);
                else
                    sync_cnt <= '0;
            end
        end
    end

    AST_SYNC_BOUND: assert property (@(posedge clk) disable iff (rst)
        sync_cnt <= SW'(SYNC_LEN)) else $error("sync count overrun"); // R11
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !found) else $error("found survived restart"); // R2
    AST_FOUND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (found && !restart) |=> found) else $error("found dropped"); // R1

endmodule

// File: rtl/wake_pg_timer.sv
module wake_pg_timer #(
    parameter int LOW_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    output logic pg_ready
);
    localparam int CW = $clog2(LOW_CYC + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || pwr_good)
            low_cnt <= '0;
        else if (low_cnt != CW'(LOW_CYC))
            low_cnt <= low_cnt + 1'b1;
    end

    assign pg_ready = (low_cnt == CW'(LOW_CYC));

    AST_PG_RESTART: assert property (@(posedge clk) disable iff (rst)
        pwr_good |=> !pg_ready) else $error("low timer not restarted"); // R8

endmodule

// File: rtl/wake_status.sv
module wake_status
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic detect,
    input  logic clr_match,
    input  logic clr_wake_irq,
    input  logic clr_pm_status,
    input  logic pm_evt_en,
    input  logic pm_evt_ovr,
    input  logic irq_global_en,
    input  logic irq_wake_en,
    input  logic ind_sel,
    input  logic ind_pol,
    output wake_flags_t flags,
    output logic pm_event,
    output logic irq,
    output logic indicator
);
    logic ind_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (detect) begin
            flags <= '{match: 1'b1, wake_irq: 1'b1, pm_status: 1'b1};
        end else begin
            if (clr_match)     flags.match     <= 1'b0;
            if (clr_wake_irq)  flags.wake_irq  <= 1'b0;
            if (clr_pm_status) flags.pm_status <= 1'b0;
        end
    end

    assign pm_event  = flags.pm_status & (pm_evt_en | pm_evt_ovr);
    assign irq       = flags.wake_irq & irq_global_en & irq_wake_en;
    assign ind_on    = ind_sel & flags.match;
    assign indicator = ind_pol ? ind_on : ~ind_on;

    AST_DETECT_SETS_ALL: assert property (@(posedge clk) disable iff (rst)
        detect |=> (flags.match && flags.wake_irq && flags.pm_status)) else $error("flags not set"); // R1
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_match && !detect) |=> !flags.match) else $error("clear ignored"); // R10
    AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
        pm_event |-> (pm_evt_en || pm_evt_ovr)) else $error("event ungated"); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_global_en && irq_wake_en)) else $error("irq ungated"); // R4

endmodule

// File: rtl/wake_frame_ctrl.sv
module wake_frame_ctrl
    import wake_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int MIN_LOW_PS    = 200000,
    parameter int SYNC_LEN      = 6,
    parameter int ADDR_COPIES   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_eof,
    input  logic        rx_err,
    input  logic [47:0] station_addr,
    input  logic        mode_en,
    input  logic        pm_evt_en,
    input  logic        pm_evt_ovr,
    input  logic        irq_global_en,
    input  logic        irq_wake_en,
    input  logic        ind_sel,
    input  logic        ind_pol,
    input  logic        pwr_good,
    input  logic        clr_match,
    input  logic        clr_wake_irq,
    input  logic        clr_pm_status,
    output logic        match_flag,
    output logic        wake_irq_flag,
    output logic        pm_status_flag,
    output logic        pm_event,
    output logic        irq,
    output logic        indicator,
    output logic        frame_drop,
    output logic        rx_suspend
);
    localparam int LOW_CYC = ceil_div(MIN_LOW_PS, CLK_PERIOD_PS);

    logic        pg_ready;
    logic        armed;
    logic        found;
    logic        detect;
    wake_flags_t flags;

    wake_pg_timer #(.LOW_CYC(LOW_CYC)) u_pg (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .pg_ready(pg_ready)
    );

    assign armed = mode_en & pg_ready & ~pwr_good;

    wake_seq_matcher #(.SYNC_LEN(SYNC_LEN), .ADDR_COPIES(ADDR_COPIES)) u_match (
        .clk(clk), .rst(rst),
        .restart(rx_sof | rx_eof | ~armed),
        .byte_vld(rx_valid), .byte_d(rx_data), .addr(station_addr),
        .found(found)
    );

    assign detect = armed & rx_eof & ~rx_err & found;

    wake_status u_stat (
        .clk(clk), .rst(rst), .detect(detect),
        .clr_match(clr_match), .clr_wake_irq(clr_wake_irq), .clr_pm_status(clr_pm_status),
        .pm_evt_en(pm_evt_en), .pm_evt_ovr(pm_evt_ovr),
        .irq_global_en(irq_global_en), .irq_wake_en(irq_wake_en),
        .ind_sel(ind_sel), .ind_pol(ind_pol),
        .flags(flags), .pm_event(pm_event), .irq(irq), .indicator(indicator)
    );

    assign match_flag     = flags.match;
    assign wake_irq_flag  = flags.wake_irq;
    assign pm_status_flag = flags.pm_status;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_drop <= 1'b0;
            rx_suspend <= 1'b0;
        end else begin
            frame_drop <= detect;
            if (pwr_good || !mode_en) rx_suspend <= 1'b0;
            else if (detect)          rx_suspend <= 1'b1;
        end
    end

    AST_SUSPEND_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (pwr_good || !mode_en) |=> !rx_suspend) else $error("suspend held"); // R7
    AST_ERR_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (rx_eof && rx_err) |=> !frame_drop) else $error("error frame dropped as wake"); // R2
    AST_DROP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_drop |-> (match_flag && wake_irq_flag && pm_status_flag && rx_suspend)) else $error("drop without flags"); // R6
    AST_PG_DISARMS: assert property (@(posedge clk) disable iff (rst)
        pwr_good |-> !armed) else $error("armed with power good"); // R8

endmodule

// File: tb/wake_frame_ctrl_test.sv
module wake_frame_ctrl_test;
    localparam int LOW_CYC  = 10;
    localparam int WIN      = 6 + 16 * 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_sof = 0, rx_valid = 0, rx_eof = 0, rx_err = 0;
    logic [7:0]  rx_data = 8'h00;
    logic [47:0] station_addr = 48'h0A_1B_2C_3D_4E_5F;
    logic mode_en = 0, pm_evt_en = 0, pm_evt_ovr = 0, irq_global_en = 0, irq_wake_en = 0;
    logic ind_sel = 0, ind_pol = 0, pwr_good = 1;
    logic clr_match = 0, clr_wake_irq = 0, clr_pm_status = 0;
    logic match_flag, wake_irq_flag, pm_status_flag, pm_event, irq, indicator, frame_drop, rx_suspend;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    wake_frame_ctrl uut (.*);

    always #10 clk = ~clk;

    // Behavioural reference model
    int       m_pgcnt;
    bit       m_match, m_wirq, m_pm, m_drop, m_susp, m_found;
    byte unsigned m_q[$];

    function automatic bit window_hit(byte unsigned q[$], logic [47:0] a);
        if (q.size() != WIN) return 0;
        for (int i = 0; i < 6; i++) if (q[i] != 8'hFF) return 0;
        for (int i = 0; i < 96; i++)
            if (q[6 + i] != a[47 - 8 * (i % 6) -: 8]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit armed, det;
        if (rst) begin
            m_pgcnt = 0; m_match = 0; m_wirq = 0; m_pm = 0; m_drop = 0; m_susp = 0;
            m_found = 0; m_q.delete();
        end else begin
            armed = mode_en && !pwr_good && (m_pgcnt >= LOW_CYC);
            det   = armed && rx_eof && !rx_err && m_found;
            if (det) begin
                m_match = 1; m_wirq = 1; m_pm = 1;
            end else begin
                if (clr_match) m_match = 0;
                if (clr_wake_irq) m_wirq = 0;
                if (clr_pm_status) m_pm = 0;
            end
            m_drop = det;
            if (pwr_good || !mode_en) m_susp = 0;
            else if (det) m_susp = 1;
            if (rx_sof || rx_eof || !armed) begin
                m_q.delete(); m_found = 0;
            end else if (rx_valid && !m_found) begin
                m_q.push_back(rx_data);
                if (m_q.size() > WIN) void'(m_q.pop_front());
                m_found = window_hit(m_q, station_addr);
            end
            m_pgcnt = pwr_good ? 0 : ((m_pgcnt < LOW_CYC) ? m_pgcnt + 1 : LOW_CYC);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit ind_on;
        if (!done) begin
            ind_on = ind_sel && m_match;
            chk("R1 R10 match_flag", match_flag, m_match);
            chk("R1 R10 wake_irq_flag", wake_irq_flag, m_wirq);
            chk("R1 R10 pm_status_flag", pm_status_flag, m_pm);
            chk("R3 pm_event", pm_event, m_pm && (pm_evt_en || pm_evt_ovr));
            chk("R4 irq", irq, m_wirq && irq_global_en && irq_wake_en);
            chk("R5 indicator", indicator, ind_pol ? ind_on : !ind_on);
            chk("R6 frame_drop", frame_drop, m_drop);
            chk("R7 rx_suspend", rx_suspend, m_susp);
        end
    end

    task automatic step(); @(posedge clk); #2; endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(); rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
            clr_match = 0; clr_wake_irq = 0; clr_pm_status = 0;
        end
    endtask

    task automatic put(input logic [7:0] b);
        step(); rx_sof = 0; rx_eof = 0; rx_valid = 1; rx_data = b;
    endtask

    task automatic sof(); step(); rx_valid = 0; rx_sof = 1; endtask

    task automatic eof(input logic err, input logic clr);
        step(); rx_valid = 0; rx_sof = 0; rx_eof = 1; rx_err = err;
        clr_match = clr; clr_wake_irq = clr; clr_pm_status = clr;
        idle(1);
    endtask

    task automatic sync(input int n); for (int i = 0; i < n; i++) put(8'hFF); endtask

    task automatic copies(input int n);
        for (int c = 0; c < n; c++)
            for (int i = 0; i < 6; i++) put(station_addr[47 - 8 * i -: 8]);
    endtask

    task automatic wake_frame(input logic err);
        sof(); put(8'h12); put(8'h34); sync(6); copies(16); put(8'h77); eof(err, 0);
    endtask

    task automatic clear_all();
        step(); clr_match = 1; clr_wake_irq = 1; clr_pm_status = 1; idle(1);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        chk("R1 reset match_flag", match_flag, 1'b0);
        chk("R7 reset rx_suspend", rx_suspend, 1'b0);
        // Not armed: power good high, mode off
        wake_frame(0);
        chk("R8 no detect while unarmed", match_flag, 1'b0);
        // Arm: power good low long enough
        mode_en = 1; pm_evt_en = 1; irq_global_en = 1; irq_wake_en = 1; ind_sel = 1; ind_pol = 1;
        step(); pwr_good = 0;
        idle(LOW_CYC + 2);
        wake_frame(0);
        chk("R1 detect sets match", match_flag, 1'b1);
        chk("R7 suspend after detect", rx_suspend, 1'b1);
        // Enable combinations
        step(); pm_evt_en = 0; pm_evt_ovr = 1; irq_global_en = 0; ind_pol = 0; idle(2);
        step(); pm_evt_ovr = 0; irq_global_en = 1; irq_wake_en = 0; ind_sel = 0; idle(2);
        // Clear mode bit releases suspend, re-arm at once (R9)
        step(); mode_en = 0; idle(1);
        chk("R7 suspend released by mode clear", rx_suspend, 1'b0);
        step(); mode_en = 1; clear_all();
        chk("R10 flags cleared", match_flag, 1'b0);
        wake_frame(0);
        chk("R9 immediate re-arm", match_flag, 1'b1);
        // Power good rises: suspend released
        step(); pwr_good = 1; idle(2);
        chk("R7 suspend released by power good", rx_suspend, 1'b0);
        clear_all();
        // Short low time: frame starts before qualification
        step(); pwr_good = 0;
        wake_frame(0);
        chk("R8 no detect before low time", match_flag, 1'b0);
        idle(LOW_CYC);
        // Error frame
        wake_frame(1);
        chk("R2 error frame ignored", match_flag, 1'b0);
        // sof mid-pattern
        sof(); sync(6); copies(8); sof(); copies(8); eof(0, 0);
        chk("R2 sof discards partial", match_flag, 1'b0);
        // Broken sequence then full pattern (R11)
        sof(); sync(6); copies(5); put(8'h00); sync(6); copies(16); eof(0, 0);
        chk("R11 restart after break", match_flag, 1'b1);
        clear_all();
        sof(); sync(9); copies(16); eof(0, 0);
        chk("R11 extra sync bytes", match_flag, 1'b1);
        clear_all();
        sof(); sync(6); copies(4); put(8'h0A); sync(6); copies(16); eof(0, 0);
        chk("R11 FF break starts new run", match_flag, 1'b1);
        // Detection beats same-cycle clear
        sof(); sync(6); copies(16); eof(0, 1);
        chk("R10 set wins over clear", match_flag, 1'b1);
        // Fifteen copies only
        clear_all();
        sof(); sync(6); copies(15); put(8'h00); eof(0, 0);
        chk("R1 fifteen copies not enough", match_flag, 1'b0);
        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule